// File: doc/BRIEF.md
# Ready/Used Neighbour Transfer Link

This block is a one-word channel between two adjacent cells of a processing array. It holds one data word and one full flag. The full flag serves as the data-ready indication. When a word is taken, the flag clears, and that clearing is the data-used indication returned to the sender. The sending side raises a flow request with a word. The receiving side raises a fetch request and gets the stored word back.

The link enforces two rules:
- A fetch only completes once the buffer holds a word.
- A flow only completes once the previous word has been taken.

Together these keep one wave of data from overrunning an earlier one. Both sides run on one shared clock.

The link is bidirectional. Each side (A and B) has both a flow port and a fetch port. A direction select chooses which side sends. The select takes effect only while the buffer is empty. A cell puts one such link towards each of its four orthogonal neighbours.

Top module: `nbr_link`

## Requirements
- R1: While reset is asserted, and after reset is released, the buffer is empty, no fetch is acknowledged, and the current direction is 0.
- R2: A flow request from the current sending side on an empty buffer is acknowledged in the same cycle. The word is stored at the next clock edge.
- R3: A fetch request from the current receiving side is acknowledged only while the buffer is full. When acknowledged, the fetch data output carries the stored word in the same cycle, and the buffer becomes empty at the next edge.
- R4: A flow request while the buffer is full is not acknowledged, and the stored word is unchanged.
- R5: A flow and a fetch in the same cycle on an empty buffer do not pass the word through. The fetch is not acknowledged in that cycle and completes in a later one.
- R6: A flow and a fetch in the same cycle on a full buffer acknowledge only the fetch. The new word is accepted in a later cycle.
- R7: The current direction output takes the value of the direction select at a clock edge only when the buffer is empty and no flow is accepted in that cycle. Otherwise it holds. Encoding: 0 means side A sends and side B receives; 1 means side B sends and side A receives.
- R8: Requests against the current direction are not acknowledged and have no effect. These are a flow on the receiving side and a fetch on the sending side.
- R9: Under arbitrary stalls on both sides, every word sent arrives exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_sel | input | 1 | Requested direction (0: A to B, 1: B to A) |
| dir_now | output | 1 | Direction currently in force |
| a_flow_req | input | 1 | Side A offers a word |
| a_flow_data | input | W | Word offered by side A |
| a_flow_ack | output | 1 | Side A word accepted this cycle |
| a_fetch_req | input | 1 | Side A asks for a word |
| a_fetch_ack | output | 1 | Side A fetch completes this cycle |
| a_fetch_data | output | W | Word returned to side A |
| b_flow_req | input | 1 | Side B offers a word |
| b_flow_data | input | W | Word offered by side B |
| b_flow_ack | output | 1 | Side B word accepted this cycle |
| b_fetch_req | input | 1 | Side B asks for a word |
| b_fetch_ack | output | 1 | Side B fetch completes this cycle |
| b_fetch_data | output | W | Word returned to side B |

## Verification
The bench checks these corner cases:
- **Same-cycle flow and fetch on an empty buffer.** A design that forwards the incoming word combinationally would acknowledge the fetch a cycle early.
- **Same-cycle flow and fetch on a full buffer.** A design that allows a refill while the word is being taken would overwrite it, or acknowledge the flow too soon.
- **Direction change requested while a word is pending.** A design that switches direction with a word still in the buffer would strand that word on the wrong side.
- **Requests against the current direction.** A design that honours them would lose or duplicate data.

A long run with random stalls on both sides catches any lost, repeated or reordered word.

// File: rtl/nbr_link.sv
module nbr_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_sel,
  output logic         dir_now,
  input  logic         a_flow_req,
  input  logic [W-1:0] a_flow_data,
  output logic         a_flow_ack,
  input  logic         a_fetch_req,
  output logic         a_fetch_ack,
  output logic [W-1:0] a_fetch_data,
  input  logic         b_flow_req,
  input  logic [W-1:0] b_flow_data,
  output logic         b_flow_ack,
  input  logic         b_fetch_req,
  output logic         b_fetch_ack,
  output logic [W-1:0] b_fetch_data
);

  logic         full;
  logic         dir_q;
  logic [W-1:0] word_q;

  wire         snd_req  = dir_q ? b_flow_req  : a_flow_req;
  wire [W-1:0] snd_data = dir_q ? b_flow_data : a_flow_data;
  wire         rcv_req  = dir_q ? a_fetch_req : b_fetch_req;

  wire flow_acc   = snd_req && !full;
  wire fetch_done = rcv_req && full;

  assign a_flow_ack   = !dir_q && flow_acc;
  assign b_flow_ack   =  dir_q && flow_acc;
  assign a_fetch_ack  =  dir_q && fetch_done;
  assign b_fetch_ack  = !dir_q && fetch_done;
  assign a_fetch_data = word_q;
  assign b_fetch_data = word_q;
  assign dir_now      = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      dir_q  <= 1'b0;
      word_q <= '0;
    end else begin
      if (flow_acc) begin
        word_q <= snd_data;
        full   <= 1'b1;
      end else if (fetch_done) begin
        full   <= 1'b0;
      end
      if (!full && !flow_acc) dir_q <= dir_sel;
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (!full && !dir_q));

  assert_fetch_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fetch_ack || b_fetch_ack) |-> full);

  assert_fetch_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fetch_ack || b_fetch_ack) |=> !full);

  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(a_fetch_ack || b_fetch_ack)) |=> (full && $stable(word_q)));

  assert_no_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flow_ack || b_flow_ack) |-> !(a_fetch_ack || b_fetch_ack));

  assert_dir_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(dir_q));

  assert_dir_respected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_flow_ack, b_flow_ack, a_fetch_ack, b_fetch_ack}) &&
    (a_flow_ack || b_fetch_ack) |-> !dir_q);

endmodule

// File: tb/sim_nbr_link.sv
module sim_nbr_link;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_sel = 1'b0;
  logic dir_now;
  logic a_flow_req = 1'b0, a_fetch_req = 1'b0, b_flow_req = 1'b0, b_fetch_req = 1'b0;
  logic [W-1:0] a_flow_data = '0, b_flow_data = '0;
  logic a_flow_ack, a_fetch_ack, b_flow_ack, b_fetch_ack;
  logic [W-1:0] a_fetch_data, b_fetch_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nbr_link #(.W(W)) u0 (
    .clk, .rst_n, .dir_sel, .dir_now,
    .a_flow_req, .a_flow_data, .a_flow_ack,
    .a_fetch_req, .a_fetch_ack, .a_fetch_data,
    .b_flow_req, .b_flow_data, .b_flow_ack,
    .b_fetch_req, .b_fetch_ack, .b_fetch_data
  );

  // {dir, afr, ad[8], afe, bfr, bd[8], bfe, exp: afa, afea, bfa, bfea, data[8], dirnow}
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b1,8'h11,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0}, // R2 flow into empty
    {1'b0,1'b1,8'h22,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R4 flow on full blocked
    {1'b0,1'b1,8'h22,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,1'b1,8'h11,1'b0}, // R6 fetch wins on full
    {1'b0,1'b1,8'h22,1'b0,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0}, // R5 no pass-through
    {1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,1'b1,8'h22,1'b0}, // R3 fetch next cycle
    {1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R3 fetch on empty
    {1'b1,1'b1,8'h33,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,1'b0,8'h00,1'b0}, // R7 flow blocks switch
    {1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R7 held while full
    {1'b1,1'b0,8'h00,1'b1,1'b1,8'h44,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R8 against direction
    {1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,1'b1,8'h33,1'b0}, // R8 word intact
    {1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}, // R7 switch pending
    {1'b1,1'b1,8'h66,1'b0,1'b1,8'h55,1'b0, 1'b0,1'b0,1'b1,1'b0,8'h00,1'b1}, // R7 B now sends
    {1'b1,1'b0,8'h00,1'b1,1'b0,8'h00,1'b1, 1'b0,1'b1,1'b0,1'b0,8'h55,1'b1}, // R8 A receives
    {1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b1}, // R7 switch back pending
    {1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,8'h00,1'b0}  // R7 back to A
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sent, recv;
    logic [33:0] v;
    repeat (3) @(negedge clk);
    b_fetch_req = 1'b1;
    #1;
    chk("R1 fetch ack in reset", int'(b_fetch_ack), 0);
    chk("R1 dir in reset", int'(dir_now), 0);
    b_fetch_req = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      v = VEC[i];
      dir_sel = v[33]; a_flow_req = v[32]; a_flow_data = v[31:24]; a_fetch_req = v[23];
      b_flow_req = v[22]; b_flow_data = v[21:14]; b_fetch_req = v[13];
      #1;
      chk("R2 a_flow_ack", int'(a_flow_ack), int'(v[12]));
      chk("R3 a_fetch_ack", int'(a_fetch_ack), int'(v[11]));
      chk("R2 b_flow_ack", int'(b_flow_ack), int'(v[10]));
      chk("R3 b_fetch_ack", int'(b_fetch_ack), int'(v[9]));
      if (v[11]) chk("R3 a_fetch_data", int'(a_fetch_data), int'(v[8:1]));
      if (v[9])  chk("R3 b_fetch_data", int'(b_fetch_data), int'(v[8:1]));
      chk("R7 dir_now", int'(dir_now), int'(v[0]));
    end

    // R1: reset drops a pending word
    @(negedge clk);
    dir_sel = 1'b0; a_fetch_req = 1'b0; b_flow_req = 1'b0; b_fetch_req = 1'b0;
    a_flow_req = 1'b1; a_flow_data = 8'h77;
    @(negedge clk);
    a_flow_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    b_fetch_req = 1'b1;
    #1;
    chk("R1 empty after reset", int'(b_fetch_ack), 0);
    b_fetch_req = 1'b0;

    // R9: random stalls on both sides, A to B
    sent = 0; recv = 0;
    for (int c = 0; c < 4000 && recv < 300; c++) begin
      @(negedge clk);
      a_flow_req  = (sent < 300) && ($urandom_range(0, 2) != 0);
      a_flow_data = 8'((sent * 7 + 3) & 8'hff);
      b_fetch_req = ($urandom_range(0, 2) != 0);
      #1;
      if (a_flow_ack) sent++;
      if (b_fetch_ack) begin
        chk("R9 order", int'(b_fetch_data), (recv * 7 + 3) & 8'hff);
        recv++;
      end
    end
    chk("R9 words received", recv, 300);
    chk("R9 words sent", sent, 300);
    @(negedge clk);
    a_flow_req = 1'b0; b_fetch_req = 1'b1;
    #1;
    chk("R9 no extra word", int'(b_fetch_ack), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule